// File: doc/BRIEF.md
# Bus Reset Pulse Sequencer

This block drives the active-low reset line of an expansion bus from three causes. The first is the supply coming up, seen as a power-good input that goes high. The second is an early warning that the supply is about to fail. The third is a one-cycle request from a software reset instruction. Supply events give a long pulse with a minimum length of 100 ms. The software request gives a short pulse of 15.5 µs. When causes overlap, the reset is extended and never cut short.

Pulse lengths are counted in cycles of a stable system clock. Each length is computed from the `CLK_HZ` parameter and rounded up, so that no minimum is undershot. The `LONG_SCALE` parameter divides only the long pulse, so a simulation can run with shorter supply pulses. The short pulse is never scaled. The pins are plain level and pulse signals with no handshake: the block accepts every input in the cycle it appears and has no back-pressure.

Top module: `bus_rst_seq`

## Requirements
- R1: While `pwr_good` is low, `bus_rst_n` is low. After `pwr_good` rises, `bus_rst_n` stays low for N_L more clock cycles and then goes high. N_L is ceil(CLK_HZ × 0.1 s / LONG_SCALE).
- R2: A high `pwr_fail_warn` sampled at a clock edge drives `bus_rst_n` low from that edge. `bus_rst_n` stays low for N_L cycles counted from the last edge at which the warning was seen.
- R3: If `pwr_good` falls at any time, including during a pulse, `bus_rst_n` is low in the cycle after. The counter then restarts at N_L.
- R4: A `sw_rst` pulse sampled with no long reset active drives `bus_rst_n` low from that edge for exactly N_S cycles. N_S is ceil(CLK_HZ × 15.5 µs) and is not scaled.
- R5: A `sw_rst` pulse during a long reset is ignored. The long pulse keeps its length, measured from its own last cause.
- R6: A `pwr_fail_warn` during a short pulse turns it into a long pulse. `bus_rst_n` stays low for N_L cycles after the warning edge.
- R7: A second `sw_rst` during a short pulse restarts the short count. The pulse ends N_S cycles after the later request, so it is never shortened.
- R8: Cycle counts round up. With CLK_HZ = 1 MHz, the short pulse is 16 cycles.
- R9: Outside these pulses `bus_rst_n` is high. Each cause, or each chain of overlapping causes, gives exactly one low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable system clock |
| pwr_good | input | 1 | Supply good, high when the supply is within range |
| pwr_fail_warn | input | 1 | Early warning of supply loss, active high |
| sw_rst | input | 1 | One-cycle software reset request |
| bus_rst_n | output | 1 | Active-low bus reset |

## Verification
The bench measures each low pulse in cycles against the length worked out from the cause that made it. A counter that loads N instead of N−1 would give a pulse one cycle too long or too short. Truncating instead of rounding up would make the 15.5-cycle pulse 15 cycles. The overlap cases carry the most weight. A design that reloads the short count on a software request during a long pulse would release the bus about 900 cycles early. A design that ignores a warning during a short pulse would release it after 16 cycles. The bench also holds power-good low for longer than N_L, which catches a design that lets the counter expire while the supply is down.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;
  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam longint LONG_NS  = 64'd100_000_000;
  localparam longint SHORT_NS = 64'd15_500;

  // cycles = ceil(hz * ns / (1e9 * scale))
  function automatic int cycles_for(input longint hz, input longint ns,
                                    input longint scale);
    longint num;
    longint den;
    num = hz * ns;
    den = NS_PER_S * scale;
    return int'((num + den - 1) / den);
  endfunction
endpackage

// File: rtl/bus_rst_arbiter.sv
module bus_rst_arbiter #(
  parameter int N_LONG  = 1000,
  parameter int N_SHORT = 16,
  parameter int CW      = 10
) (
  input  logic          pwr_good,
  input  logic          pwr_fail_warn,
  input  logic          sw_rst,
  input  logic          long_active,
  output logic          load,
  output logic          load_long,
  output logic [CW-1:0] load_val
);
  logic long_req;
  logic short_req;

  always_comb begin
    long_req  = !pwr_good || pwr_fail_warn;
    short_req = sw_rst && !long_active;
    load      = long_req || short_req;
    load_long = long_req;
    load_val  = long_req ? CW'(N_LONG - 1) : CW'(N_SHORT - 1);
  end
endmodule

// File: rtl/bus_rst_counter.sv
module bus_rst_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          pwr_good,
  input  logic          load,
  input  logic          load_long,
  input  logic [CW-1:0] load_val,
  output logic          low_q,
  output logic          long_q
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q  <= load_val;
      low_q  <= 1'b1;
      long_q <= load_long;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      low_q  <= 1'b0;
      long_q <= 1'b0;
    end
  end

  AST_LONG_NOT_CUT: assert property (@(posedge clk) disable iff (!pwr_good)
    (long_q && cnt_q > 1) |=> (long_q && low_q)); // R5

  AST_LONG_ENDS_WITH_RELEASE: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(long_q) |-> !low_q); // R9
endmodule

// File: rtl/bus_rst_seq.sv
module bus_rst_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int LONG_SCALE = 1
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic pwr_fail_warn,
  input  logic sw_rst,
  output logic bus_rst_n
);
  import bus_rst_pkg::*;

  localparam int N_LONG  = cycles_for(longint'(CLK_HZ), LONG_NS, longint'(LONG_SCALE));
  localparam int N_SHORT = cycles_for(longint'(CLK_HZ), SHORT_NS, 64'd1);
  localparam int N_MAX   = (N_LONG > N_SHORT) ? N_LONG : N_SHORT;
  localparam int CW      = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  logic          load;
  logic          load_long;
  logic [CW-1:0] load_val;
  logic          low_q;
  logic          long_q;

  bus_rst_arbiter #(.N_LONG(N_LONG), .N_SHORT(N_SHORT), .CW(CW)) arb_i (
    .pwr_good      (pwr_good),
    .pwr_fail_warn (pwr_fail_warn),
    .sw_rst        (sw_rst),
    .long_active   (long_q),
    .load          (load),
    .load_long     (load_long),
    .load_val      (load_val)
  );

  bus_rst_counter #(.CW(CW)) cnt_i (
    .clk       (clk),
    .pwr_good  (pwr_good),
    .load      (load),
    .load_long (load_long),
    .load_val  (load_val),
    .low_q     (low_q),
    .long_q    (long_q)
  );

  assign bus_rst_n = !low_q;

  AST_DOWN_HOLDS_LOW: assert property (@(posedge clk)
    !pwr_good |=> !bus_rst_n); // R3

  AST_WARN_NEXT_LOW: assert property (@(posedge clk) disable iff (!pwr_good)
    pwr_fail_warn |=> !bus_rst_n); // R2

  AST_SW_NEXT_LOW: assert property (@(posedge clk) disable iff (!pwr_good)
    sw_rst |=> !bus_rst_n); // R4
endmodule

// File: tb/bus_rst_seq_tb_top.sv
`timescale 1ns/1ps
module bus_rst_seq_tb_top;
  localparam int CLK_PERIOD = 1000;
  localparam int HZ    = 1_000_000;
  localparam int SCALE = 100;
  localparam int NL    = 1000; // ceil(1e6*0.1/100)
  localparam int NS    = 16;   // ceil(15.5)

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic warn = 1'b0;
  logic sw = 1'b0;
  logic bus_rst_n;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_rst_seq #(.CLK_HZ(HZ), .LONG_SCALE(SCALE)) dut_i (
    .clk(clk), .pwr_good(pwr_good), .pwr_fail_warn(warn),
    .sw_rst(sw), .bus_rst_n(bus_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(input string req, input int len);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  task automatic pulse_sw();
    sw = 1'b1; step(1); sw = 1'b0;
  endtask

  task automatic pulse_warn();
    warn = 1'b1; step(1); warn = 1'b0;
  endtask

  // monitor: measure each low pulse and compare against the scoreboard
  int run_len = 0;
  always @(negedge clk) begin
    if (bus_rst_n === 1'b0) run_len++;
    else if (run_len != 0) begin
      if (exp_q.size() == 0) check("R9 unexpected pulse", run_len, 0);
      else check(tag_q.pop_front(), run_len, exp_q.pop_front());
      run_len = 0;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1);
    check("R1 reset state low", int'(bus_rst_n), 0);
    // power-up: first load edge 1, last at edge 20
    step(19);
    expect_pulse("R1 power-up width", 19 + NL);
    pwr_good = 1'b1;
    step(NL - 1);
    check("R1 still low before N_L", int'(bus_rst_n), 0);
    step(1);
    check("R1 released after N_L", int'(bus_rst_n), 1);
    step(20);

    // software pulse, rounding up
    expect_pulse("R4 R8 short width", NS);
    pulse_sw();
    check("R4 low next cycle", int'(bus_rst_n), 0);
    step(40);
    check("R9 idle high", int'(bus_rst_n), 1);

    // second request restarts the short pulse
    expect_pulse("R7 restart width", 5 + NS);
    pulse_sw(); step(4); pulse_sw();
    step(40);

    // warning alone
    expect_pulse("R2 warn width", NL);
    pulse_warn();
    check("R2 low next cycle", int'(bus_rst_n), 0);
    step(NL + 20);

    // warning during a short pulse
    expect_pulse("R6 extend width", 5 + NL);
    pulse_sw(); step(4); pulse_warn();
    step(NL + 20);

    // software request during a long pulse
    expect_pulse("R5 ignored width", NL);
    pulse_warn(); step(99); pulse_sw();
    step(NL + 20);

    // warning then supply loss held past N_L
    expect_pulse("R3 loss width", 1749 + NL);
    pulse_warn(); step(199);
    pwr_good = 1'b0;
    step(1);
    check("R3 low when down", int'(bus_rst_n), 0);
    step(1549);
    pwr_good = 1'b1;
    step(NL + 20);

    // supply dip during a short pulse
    expect_pulse("R3 dip width", 5 + NL);
    pulse_sw(); step(4);
    pwr_good = 1'b0; step(1); pwr_good = 1'b1;
    step(NL + 20);

    check("R9 final high", int'(bus_rst_n), 1);
    check("R9 all pulses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule